// File: doc/BRIEF.md
# Four-Phase Machine-Cycle Sequencer with Memory Stall

This block paces a processor datapath. Every clock is one phase. Four phases make a machine cycle, and they repeat in a fixed ring. In each phase the block raises the enable strobes for the datapath work of that phase: advancing the pipeline latches, reading operands, routing the immediate, copying write data to the pins, capturing read data, committing a result, driving the address and decoding.

When the instruction in the execute stage accesses memory, the sequencer holds the pipeline for one full machine cycle. It sets a suspend flag in phase three, and it clears that flag in phase three of the next machine cycle. While the flag is set, the pipeline-moving strobes are withheld. The memory-facing strobes keep running, so that the access itself can finish.

An optional interrupt phase (parameter `IRQ_EN`) can follow phase four when an interrupt is requested. It always hands control back to phase one.

Top module: `quad_phase_seq`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) puts the block in phase one (`phase_o` = 00001) with `stall_o` low.
- R2: `phase_o` is one-hot, with bit 0 = phase one, bit 1 = phase two, bit 2 = phase three, bit 3 = phase four and bit 4 = interrupt phase. Phases advance one per clock in the order one, two, three, four, then back to one.
- R3: In phase one, `adv_o` and `opread_o` are high only when `stall_o` is low.
- R4: In phase two, `wrcopy_o` is high on every pass. `imm_o` is high only when `stall_o` is low.
- R5: In phase three, `capture_o` is high on every pass, whether or not the pipeline is stalled.
- R6: In phase three with `stall_o` low and `mem_op_i` high, `commit_o` is high and `stall_o` is high from the next clock onward.
- R7: In phase three with `stall_o` high, `stall_o` is low from the next clock onward. During that pass `mem_op_i` is ignored: `commit_o` stays low and no new stall starts.
- R8: In phase four, `addr_o` is high on every pass. `decode_o` is high only when `stall_o` is low.
- R9: In phase four with `irq_i` high, the next phase is the interrupt phase, and this takes priority over returning to phase one. The interrupt phase raises no strobe and is always followed by phase one. `irq_i` has no effect in any other phase.
- R10: Every strobe is high only in its own phase, so each pulse lasts a single clock. `stall_o` changes only on the clock that ends phase three, or on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one phase per cycle |
| rst_i | input | 1 | Synchronous reset, active high |
| mem_op_i | input | 1 | Execute-stage instruction is a load or store |
| irq_i | input | 1 | Interrupt request, sampled in phase four |
| phase_o | output | NPH (5) | One-hot current phase |
| adv_o | output | 1 | Advance pipeline latches (phase one) |
| opread_o | output | 1 | Read source registers into ALU inputs (phase one) |
| imm_o | output | 1 | Route immediate to ALU (phase two) |
| wrcopy_o | output | 1 | Copy write data to memory pins (phase two) |
| capture_o | output | 1 | Capture memory read data (phase three) |
| commit_o | output | 1 | Commit previous result (phase three) |
| addr_o | output | 1 | Drive memory address (phase four) |
| decode_o | output | 1 | Decode next instruction (phase four) |
| stall_o | output | 1 | Pipeline suspended |

## Verification
The hardest state to reach from the ports is phase three with the pipeline already stalled while `mem_op_i` is still high. This is the only case that shows `mem_op_i` being ignored and no back-to-back stall forming. The bench reaches it by holding `mem_op_i` high for hundreds of cycles, so that every other machine cycle is a stalled one. It also mixes this with interrupt requests that insert extra phases between the cycle that sets the stall and the cycle that clears it. A mid-run reset is applied while a stall is pending, to confirm the flag is dropped.

// File: rtl/qps_pkg.sv
package qps_pkg;
   typedef enum logic [2:0] {
      PH_ONE   = 3'd0,
      PH_TWO   = 3'd1,
      PH_THREE = 3'd2,
      PH_FOUR  = 3'd3,
      PH_TRAP  = 3'd4
   } phase_e;

   typedef struct packed {
      logic advance;
      logic opread;
      logic immroute;
      logic wrcopy;
      logic capture;
      logic commit;
      logic addrdrv;
      logic decode;
   } strobe_s;
endpackage

// File: rtl/qps_ring.sv
module qps_ring
   import qps_pkg::*;
#(
   parameter int IRQ_EN = 1
) (
   input  logic   clk_i,
   input  logic   rst_i,
   input  logic   irq_i,
   output phase_e ph_o
);
   phase_e ph_q, ph_d;

   generate
      if (IRQ_EN != 0 && IRQ_EN != 1) begin : g_bad_cfg
         $error("qps_ring: IRQ_EN must be 0 or 1");
      end
   endgenerate

   generate
      if (IRQ_EN == 1) begin : g_trap
         always_comb begin
            unique case (ph_q)
               PH_ONE:   ph_d = PH_TWO;
               PH_TWO:   ph_d = PH_THREE;
               PH_THREE: ph_d = PH_FOUR;
               PH_FOUR:  ph_d = irq_i ? PH_TRAP : PH_ONE;
               default:  ph_d = PH_ONE;
            endcase
         end
         p_trap_entry_r9: assert property (@(posedge clk_i) disable iff (rst_i)
            (ph_q == PH_FOUR && irq_i) |=> (ph_q == PH_TRAP));
         p_trap_exit_r9: assert property (@(posedge clk_i) disable iff (rst_i)
            (ph_q == PH_TRAP) |=> (ph_q == PH_ONE));
      end else begin : g_notrap
         logic unused_irq;
         assign unused_irq = irq_i;
         always_comb begin
            unique case (ph_q)
               PH_ONE:   ph_d = PH_TWO;
               PH_TWO:   ph_d = PH_THREE;
               PH_THREE: ph_d = PH_FOUR;
               default:  ph_d = PH_ONE;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) ph_q <= PH_ONE;
      else       ph_q <= ph_d;
   end

   assign ph_o = ph_q;

   p_ring_order_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_q == PH_ONE) |=> (ph_q == PH_TWO));
   p_ring_mid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_q == PH_TWO || ph_q == PH_THREE) |=> (ph_q == $past(ph_q) + 3'd1));
   p_ring_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (ph_q == PH_FOUR && !irq_i) |=> (ph_q == PH_ONE));
endmodule

// File: rtl/qps_hold.sv
module qps_hold
   import qps_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_i,
   input  phase_e ph_i,
   input  logic   mem_op_i,
   output logic   stall_o
);
   logic stall_q;
   logic decide;

   assign decide = (ph_i == PH_THREE);

   always_ff @(posedge clk_i) begin
      if (rst_i)
         stall_q <= 1'b0;
      else if (decide)
         stall_q <= stall_q ? 1'b0 : mem_op_i;
   end

   assign stall_o = stall_q;

   p_stall_set_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (decide && !stall_q && mem_op_i) |=> stall_q);
   p_stall_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (decide && stall_q) |=> !stall_q);
   p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      !decide |=> $stable(stall_q));
endmodule

// File: rtl/qps_strobes.sv
module qps_strobes
   import qps_pkg::*;
(
   input  phase_e  ph_i,
   input  logic    stall_i,
   input  logic    mem_op_i,
   output strobe_s stb_o
);
   logic run;
   assign run = !stall_i;

   always_comb begin
      stb_o = '0;
      unique case (ph_i)
         PH_ONE: begin
            stb_o.advance = run;
            stb_o.opread  = run;
         end
         PH_TWO: begin
            stb_o.wrcopy   = 1'b1;
            stb_o.immroute = run;
         end
         PH_THREE: begin
            stb_o.capture = 1'b1;
            stb_o.commit  = run && mem_op_i;
         end
         PH_FOUR: begin
            stb_o.addrdrv = 1'b1;
            stb_o.decode  = run;
         end
         default: stb_o = '0;
      endcase
   end
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
   import qps_pkg::*;
#(
   parameter int IRQ_EN = 1,
   localparam int NPH   = 4 + IRQ_EN
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           mem_op_i,
   input  logic           irq_i,
   output logic [NPH-1:0] phase_o,
   output logic           adv_o,
   output logic           opread_o,
   output logic           imm_o,
   output logic           wrcopy_o,
   output logic           capture_o,
   output logic           commit_o,
   output logic           addr_o,
   output logic           decode_o,
   output logic           stall_o
);
   phase_e  ph;
   logic    stall;
   strobe_s stb;

   qps_ring #(.IRQ_EN(IRQ_EN)) ring_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .irq_i (irq_i),
      .ph_o  (ph)
   );

   qps_hold hold_i (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .ph_i     (ph),
      .mem_op_i (mem_op_i),
      .stall_o  (stall)
   );

   qps_strobes strobes_i (
      .ph_i     (ph),
      .stall_i  (stall),
      .mem_op_i (mem_op_i),
      .stb_o    (stb)
   );

   generate
      for (genvar i = 0; i < NPH; i++) begin : g_onehot
         assign phase_o[i] = (ph == phase_e'(i));
      end
   endgenerate

   assign adv_o     = stb.advance;
   assign opread_o  = stb.opread;
   assign imm_o     = stb.immroute;
   assign wrcopy_o  = stb.wrcopy;
   assign capture_o = stb.capture;
   assign commit_o  = stb.commit;
   assign addr_o    = stb.addrdrv;
   assign decode_o  = stb.decode;
   assign stall_o   = stall;

   p_onehot_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(phase_o) == 1);
   p_commit_single_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      commit_o |=> !commit_o);
   p_no_decode_after_commit_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      commit_o |=> (addr_o && !decode_o));
   p_capture_then_addr_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      capture_o |=> addr_o);
   p_wrcopy_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      wrcopy_o |=> (capture_o && !wrcopy_o));
endmodule

// File: tb/quad_phase_seq_tb_top.sv
`timescale 1ns/1ps
module quad_phase_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       mem = 1'b0;
   logic       irq = 1'b0;
   logic [4:0] phase;
   logic adv, opread, imm, wrcopy, capture, commit, addr, decode, stall;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int  m_ph;
   bit  m_stall;
   bit  m_valid = 0;
   bit  m_after_rst = 0;

   always #2 clk = ~clk;

   quad_phase_seq #(.IRQ_EN(1)) dut_i (
      .clk_i(clk), .rst_i(rst), .mem_op_i(mem), .irq_i(irq),
      .phase_o(phase), .adv_o(adv), .opread_o(opread), .imm_o(imm),
      .wrcopy_o(wrcopy), .capture_o(capture), .commit_o(commit),
      .addr_o(addr), .decode_o(decode), .stall_o(stall)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic step(input bit r, input bit m, input bit q);
      @(negedge clk);
      rst = r; mem = m; irq = q;
      #1;
      if (m_valid) begin
         bit run;
         run = !m_stall;
         if (m_after_rst) begin
            chk(phase == 5'b00001, "R1 phase after reset", phase, 1);
            chk(stall == 1'b0, "R1 stall after reset", stall, 0);
         end
         chk(phase == (5'b1 << m_ph), (m_ph == 4) ? "R9 phase" : "R2 phase", phase, 5'b1 << m_ph);
         chk(stall == m_stall, (m_ph == 3) ? "R7 stall window" : "R10 stall", stall, m_stall);
         chk(adv == (m_ph == 0 && run), "R3 adv", adv, m_ph == 0 && run);
         chk(opread == (m_ph == 0 && run), "R3 opread", opread, m_ph == 0 && run);
         chk(wrcopy == (m_ph == 1), "R4 wrcopy", wrcopy, m_ph == 1);
         chk(imm == (m_ph == 1 && run), "R4 imm", imm, m_ph == 1 && run);
         chk(capture == (m_ph == 2), "R5 capture", capture, m_ph == 2);
         chk(commit == (m_ph == 2 && run && m), m_stall ? "R7 commit ignored" : "R6 commit",
             commit, m_ph == 2 && run && m);
         chk(addr == (m_ph == 3), "R8 addr", addr, m_ph == 3);
         chk(decode == (m_ph == 3 && run), "R8 decode", decode, m_ph == 3 && run);
         if (m_ph == 4)
            chk({adv, opread, imm, wrcopy, capture, commit, addr, decode} == 8'h00,
                "R9 trap strobes", {adv, opread, imm, wrcopy, capture, commit, addr, decode}, 0);
      end
      m_after_rst = r;
      if (r) begin
         m_ph = 0; m_stall = 0; m_valid = 1;
      end else if (m_valid) begin
         if (m_ph == 2) m_stall = m_stall ? 1'b0 : m;
         case (m_ph)
            0: m_ph = 1;
            1: m_ph = 2;
            2: m_ph = 3;
            3: m_ph = q ? 4 : 0;
            default: m_ph = 0;
         endcase
      end
   endtask

   initial begin
      step(1, 0, 0);
      step(1, 1, 1);
      // Pattern A: idle, no memory ops, no interrupts
      for (int i = 0; i < 400; i++) step(0, 0, 0);
      // Pattern B: memory op held high, back-to-back stall attempts (R6, R7)
      for (int i = 0; i < 400; i++) step(0, 1, 0);
      // Pattern C: interrupt always requested (R9)
      for (int i = 0; i < 400; i++) step(0, 0, 1);
      // Pattern D: memory op and interrupt together
      for (int i = 0; i < 400; i++) step(0, 1, 1);
      // Pattern E: sweep all input pairs at every phase position, with a mid-run reset
      for (int i = 0; i < 2000; i++) begin
         int h;
         h = (i * 37 + (i >> 3) * 11) ^ (i >> 5);
         if (i == 1003 || i == 1004) step(1, 1, 0);
         else step(0, h[0], h[1] & h[2]);
      end
      // Reset while a stall is pending (R1)
      step(0, 0, 0); step(0, 0, 0);
      for (int i = 0; i < 8; i++) step(0, 1, 0);
      step(1, 0, 0);
      for (int i = 0; i < 20; i++) step(0, 0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule